// File: doc/BRIEF.md
# Timebase Synchronization Sequencer

This block is the per-core sequencer that brings a core's timebase into step with a chip-wide time-of-day source. Firmware steers it by writing a 64-bit control word and observes it by reading the same word back. That word holds the current state, the state before the most recent transition, a running flag, a firmware-misuse flag and a flag that records a seen sync pulse. Alongside firmware writes, the sequencer reacts to a sync pulse from the time-of-day source, to a strobe that says a time-of-day value has been delivered, and to notices that the upper or lower half of the timebase was written.

The normal bring-up is: load the time-of-day module (the state settles in NOT_SET), request the move of the time-of-day value into the timebase (SYNC_WAIT, with ready-for-TOD raised), wait for a sync pulse (GET_TOD), then wait for the delivered strobe (TB_RUNNING). Illegal requests drop the machine into TB_ERROR. Only a clear request leaves that state.

Top module: `tbsync_fsm`

## Requirements
- R1: After synchronous reset, the read word is all zero and ready_for_tod is 0. The state codes are RESET=0, SEND_TOD_MOD=1, NOT_SET=2, SYNC_WAIT=6, GET_TOD=7, TB_RUNNING=8 and TB_ERROR=9. The current state is never 1, 3, 4, 5 or above 9.
- R2: A write with the load bit (bit 48) set in state 0, 2, 6 or 8 passes through 1 and settles in NOT_SET: the current state reads 2, the last state reads 1, and ready_for_tod drops. The load bit always reads back as 0.
- R3: A write with the load bit set in GET_TOD enters TB_ERROR and sets the firmware-error flag (bit 41).
- R4: A write with the move bit (bit 49) set in NOT_SET enters SYNC_WAIT and raises ready_for_tod. In SYNC_WAIT or GET_TOD such a write keeps the state. In any other state it enters TB_ERROR, sets the firmware-error flag and keeps the move bit. ready_for_tod is 1 only in SYNC_WAIT or GET_TOD.
- R5: A sync pulse in SYNC_WAIT advances the machine to GET_TOD. Outside TB_ERROR a sync pulse sets the sync-seen flag (bit 42). Any write clears that flag.
- R6: A delivered strobe that arrives while ready_for_tod is 1 is remembered. In GET_TOD, a remembered or present strobe moves the machine to TB_RUNNING and clears the move bit and ready_for_tod. The valid flag (bit 40) is 1 exactly in TB_RUNNING.
- R7: Timebase writes are handled per state. In NOT_SET, upper-half and lower-half writes both leave the state unchanged. In TB_RUNNING an upper-half write leaves it unchanged, but a lower-half write enters TB_ERROR. Either kind of write in SYNC_WAIT or GET_TOD enters TB_ERROR. None of these sets the firmware-error flag.
- R8: A write with both the load and move bits set enters TB_ERROR from any state, with the firmware-error flag set and the move bit reading 1.
- R9: A write with the clear bit (bit 50) set, and not both load and move, returns the machine to RESET. It clears the move bit, the firmware-error flag, ready_for_tod and any remembered strobe.
- R10: On every transition, the previous 4-bit current state (bits 31:28) is copied into the last-state field (bits 27:24).
- R11: In TB_ERROR, any write without the clear bit changes nothing except that it sets the firmware-error flag. A write of 1 to bit 41 clears that flag, unless the same write sets it again.
- R12: If a write and external events arrive in the same cycle, only the write acts. The events in that cycle are dropped. Results appear in the read word on the clock edge that follows the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 64 | Control word write value |
| rd_data | output | 64 | Control word read value |
| sync_pulse | input | 1 | Sync pulse from the time-of-day source |
| tod_delivered | input | 1 | Time-of-day value delivered strobe |
| tb_upper_wr | input | 1 | Upper-half timebase write event |
| tb_lower_wr | input | 1 | Lower-half timebase write event |
| ready_for_tod | output | 1 | Core is ready to take a time-of-day value |

## Verification
A firmware write and a sync pulse can land in the same cycle. The bench drives both in one cycle while the machine sits in SYNC_WAIT, pairing the pulse with a write of the move bit, which by itself would leave the state unchanged. The write must win. The next read must therefore still show SYNC_WAIT with the sync-seen flag clear, where the pulse alone would have produced GET_TOD with the flag set. A delivered strobe that arrives before the sync pulse is also checked: it must be kept, so that the machine runs one cycle after reaching GET_TOD.

// File: rtl/tbsync_pkg.sv
package tbsync_pkg;

    localparam int REG_W       = 64;
    localparam int ST_W        = 4;
    localparam int CUR_LSB     = 28;
    localparam int LAST_LSB    = CUR_LSB - ST_W;
    localparam int VALID_BIT   = 40;
    localparam int FWERR_BIT   = 41;
    localparam int SYNCOCC_BIT = 42;
    localparam int LOAD_BIT    = 48;
    localparam int MOVE_BIT    = 49;
    localparam int CLR_BIT     = 50;

    typedef enum logic [ST_W-1:0] {
        ST_RESET    = 4'd0,
        ST_SEND     = 4'd1,
        ST_NOTSET   = 4'd2,
        ST_SYNCWAIT = 4'd6,
        ST_GETTOD   = 4'd7,
        ST_RUNNING  = 4'd8,
        ST_ERROR    = 4'd9
    } tb_state_e;

    typedef struct packed {
        tb_state_e cur;
        tb_state_e last;
        logic      fw_err;
        logic      sync_occ;
        logic      move;
        logic      ready;
        logic      delivered;
    } tb_regs_t;

    typedef struct packed {
        logic valid;
        logic load;
        logic move;
        logic clr;
        logic fw_clr;
    } wr_cmd_t;

    // Shift the present state into the history field and install a new one.
    function automatic tb_regs_t tb_enter(tb_regs_t r, tb_state_e s);
        tb_regs_t o;
        o      = r;
        o.last = r.cur;
        o.cur  = s;
        return o;
    endfunction

    // Common side effects of dropping into the error state.
    function automatic tb_regs_t tb_fail(tb_regs_t r, logic flag_fw);
        tb_regs_t o;
        o           = tb_enter(r, ST_ERROR);
        o.ready     = 1'b0;
        o.delivered = 1'b0;
        if (flag_fw) o.fw_err = 1'b1;
        return o;
    endfunction

endpackage

// File: rtl/tbsync_wrdec.sv
module tbsync_wrdec
    import tbsync_pkg::*;
(
    input  logic             en,
    input  logic [REG_W-1:0] data,
    output wr_cmd_t          cmd
);
    logic unused_data_bits;

    always_comb begin
        cmd.valid  = en;
        cmd.load   = en & data[LOAD_BIT];
        cmd.move   = en & data[MOVE_BIT];
        cmd.clr    = en & data[CLR_BIT];
        cmd.fw_clr = en & data[FWERR_BIT];
    end

    assign unused_data_bits = ^data;
endmodule

// File: rtl/tbsync_next.sv
module tbsync_next
    import tbsync_pkg::*;
(
    input  tb_regs_t q,
    input  wr_cmd_t  cmd,
    input  logic     sync_pulse,
    input  logic     tod_delivered,
    input  logic     tb_upper_wr,
    input  logic     tb_lower_wr,
    output tb_regs_t d
);
    logic tb_touch;
    assign tb_touch = tb_upper_wr | tb_lower_wr;

    always_comb begin
        d = q;
        if (cmd.valid) begin
            d.sync_occ = 1'b0;
            if (cmd.fw_clr) d.fw_err = 1'b0;
            if (cmd.load && cmd.move) begin
                d      = tb_fail(d, 1'b1);
                d.move = 1'b1;
            end else if (cmd.clr) begin
                d           = tb_enter(d, ST_RESET);
                d.move      = 1'b0;
                d.fw_err    = 1'b0;
                d.ready     = 1'b0;
                d.delivered = 1'b0;
            end else if (q.cur == ST_ERROR) begin
                d.fw_err = 1'b1;
            end else begin
                d.move = cmd.move;
                if (cmd.load) begin
                    if (q.cur == ST_GETTOD) begin
                        d = tb_fail(d, 1'b1);
                    end else begin
                        d           = tb_enter(d, ST_SEND);
                        d           = tb_enter(d, ST_NOTSET);
                        d.ready     = 1'b0;
                        d.delivered = 1'b0;
                    end
                end else if (cmd.move) begin
                    case (q.cur)
                        ST_NOTSET: begin
                            d       = tb_enter(d, ST_SYNCWAIT);
                            d.ready = 1'b1;
                        end
                        ST_SYNCWAIT, ST_GETTOD: ;
                        default: d = tb_fail(d, 1'b1);
                    endcase
                end
            end
        end else begin
            if (sync_pulse && q.cur != ST_ERROR) d.sync_occ = 1'b1;
            if (tod_delivered && q.ready) d.delivered = 1'b1;
            case (q.cur)
                ST_SYNCWAIT: begin
                    if (tb_touch)        d = tb_fail(d, 1'b0);
                    else if (sync_pulse) d = tb_enter(d, ST_GETTOD);
                end
                ST_GETTOD: begin
                    if (tb_touch) begin
                        d = tb_fail(d, 1'b0);
                    end else if (d.delivered) begin
                        d           = tb_enter(d, ST_RUNNING);
                        d.move      = 1'b0;
                        d.ready     = 1'b0;
                        d.delivered = 1'b0;
                    end
                end
                ST_RUNNING: begin
                    if (tb_lower_wr) d = tb_fail(d, 1'b0);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tbsync_pack.sv
module tbsync_pack
    import tbsync_pkg::*;
(
    input  tb_regs_t         q,
    output logic [REG_W-1:0] word
);
    logic unused_pack;
    assign unused_pack = q.delivered;

    always_comb begin
        word                           = '0;
        word[CUR_LSB +: ST_W]          = q.cur;
        word[LAST_LSB +: ST_W]         = q.last;
        word[VALID_BIT]                = (q.cur == ST_RUNNING);
        word[FWERR_BIT]                = q.fw_err;
        word[SYNCOCC_BIT]              = q.sync_occ;
        word[MOVE_BIT]                 = q.move;
    end
endmodule

// File: rtl/tbsync_fsm.sv
module tbsync_fsm
    import tbsync_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             sync_pulse,
    input  logic             tod_delivered,
    input  logic             tb_upper_wr,
    input  logic             tb_lower_wr,
    output logic             ready_for_tod
);
    wr_cmd_t  cmd;
    tb_regs_t regs_q;
    tb_regs_t regs_d;

    tbsync_wrdec u_dec (
        .en   (wr_en),
        .data (wr_data),
        .cmd  (cmd)
    );

    tbsync_next u_next (
        .q             (regs_q),
        .cmd           (cmd),
        .sync_pulse    (sync_pulse),
        .tod_delivered (tod_delivered),
        .tb_upper_wr   (tb_upper_wr),
        .tb_lower_wr   (tb_lower_wr),
        .d             (regs_d)
    );

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    tbsync_pack u_pack (
        .q    (regs_q),
        .word (rd_data)
    );

    assign ready_for_tod = regs_q.ready;
endmodule

// File: rtl/tbsync_fsm_chk.sv
module tbsync_fsm_chk
    import tbsync_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             sync_pulse,
    input logic             tb_upper_wr,
    input logic             tb_lower_wr,
    input logic             ready_for_tod
);
    logic [ST_W-1:0] cur;
    logic [ST_W-1:0] last;
    assign cur  = rd_data[CUR_LSB +: ST_W];
    assign last = rd_data[LAST_LSB +: ST_W];

    p_legal_code_r1: assert property (@(posedge clk) disable iff (rst)
        (cur == 4'd0 || cur == 4'd2 || cur == 4'd6 || cur == 4'd7 ||
         cur == 4'd8 || cur == 4'd9));

    p_ready_states_r4: assert property (@(posedge clk) disable iff (rst)
        ready_for_tod |-> (cur == 4'd6 || cur == 4'd7));

    p_sync_adv_r5: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && sync_pulse && !tb_upper_wr && !tb_lower_wr && cur == 4'd6)
        |=> (cur == 4'd7));

    p_lower_err_r7: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && tb_lower_wr && cur == 4'd8) |=> (cur == 4'd9));

    p_both_err_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[LOAD_BIT] && wr_data[MOVE_BIT])
        |=> (cur == 4'd9 && rd_data[FWERR_BIT]));

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[CLR_BIT] && !(wr_data[LOAD_BIT] && wr_data[MOVE_BIT]))
        |=> (cur == 4'd0 && !ready_for_tod && !rd_data[FWERR_BIT]));

    p_last_shadow_r10: assert property (@(posedge clk) disable iff (rst)
        (cur != $past(cur) && !(cur == 4'd2 && last == 4'd1))
        |-> (last == $past(cur)));
endmodule

bind tbsync_fsm tbsync_fsm_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .sync_pulse    (sync_pulse),
    .tb_upper_wr   (tb_upper_wr),
    .tb_lower_wr   (tb_lower_wr),
    .ready_for_tod (ready_for_tod)
);

// File: tb/sim_tbsync_fsm.sv
module sim_tbsync_fsm;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] W_LOAD = 64'd1 << 48;
    localparam logic [63:0] W_MOVE = 64'd1 << 49;
    localparam logic [63:0] W_CLR  = 64'd1 << 50;
    localparam logic [63:0] W_FW   = 64'd1 << 41;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        sync_pulse = 1'b0;
    logic        tod_delivered = 1'b0;
    logic        tb_upper_wr = 1'b0;
    logic        tb_lower_wr = 1'b0;
    logic [63:0] rd_data;
    logic        ready_for_tod;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] rd;
        logic        rdy;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tbsync_fsm u0 (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .rd_data       (rd_data),
        .sync_pulse    (sync_pulse),
        .tod_delivered (tod_delivered),
        .tb_upper_wr   (tb_upper_wr),
        .tb_lower_wr   (tb_lower_wr),
        .ready_for_tod (ready_for_tod)
    );

    // Read word from its fields: cur 31:28, last 27:24, valid 40, fw 41, sync 42, move 49.
    function automatic logic [63:0] mk(int cur, int last, bit v, bit fw, bit so, bit mv);
        logic [63:0] w;
        w        = '0;
        w[31:28] = cur[3:0];
        w[27:24] = last[3:0];
        w[40]    = v;
        w[41]    = fw;
        w[42]    = so;
        w[49]    = mv;
        return w;
    endfunction

    // Driver: applies one cycle of stimulus and queues the expected result.
    task automatic step(bit we, logic [63:0] wd, bit sp, bit td, bit up, bit lo,
                        logic [63:0] erd, bit erdy, string tag);
        exp_t e;
        @(negedge clk);
        wr_en = we; wr_data = wd; sync_pulse = sp;
        tod_delivered = td; tb_upper_wr = up; tb_lower_wr = lo;
        e.rd = erd; e.rdy = erdy; e.tag = tag;
        sbq.push_back(e);
    endtask

    // Monitor: pops and compares just after each active edge.
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (sbq.size() > 0) begin
            e = sbq.pop_front();
            checks++;
            if (rd_data !== e.rd || ready_for_tod !== e.rdy) begin
                errors++;
                $display("FAIL %s: rd=%h ready=%0b expected rd=%h ready=%0b",
                         e.tag, rd_data, ready_for_tod, e.rd, e.rdy);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step(0, 0, 0, 0, 0, 0, mk(0,0,0,0,0,0), 0, "R1 reset state");
        step(1, W_LOAD, 0, 0, 0, 0, mk(2,1,0,0,0,0), 0, "R2 load from RESET");
        step(0, 0, 0, 0, 1, 0, mk(2,1,0,0,0,0), 0, "R7 upper write in NOT_SET");
        step(0, 0, 0, 0, 0, 1, mk(2,1,0,0,0,0), 0, "R7 lower write in NOT_SET");
        step(1, W_MOVE, 0, 0, 0, 0, mk(6,2,0,0,0,1), 1, "R4 R10 move in NOT_SET");
        step(0, 0, 0, 1, 0, 0, mk(6,2,0,0,0,1), 1, "R6 early strobe held");
        step(0, 0, 1, 0, 0, 0, mk(7,6,0,0,1,1), 1, "R5 sync pulse advances");
        step(0, 0, 0, 0, 0, 0, mk(8,7,1,0,1,0), 0, "R6 held strobe runs");
        step(1, 0, 0, 0, 0, 0, mk(8,7,1,0,0,0), 0, "R5 write clears sync flag");
        step(0, 0, 0, 0, 1, 0, mk(8,7,1,0,0,0), 0, "R7 upper write while running");
        step(0, 0, 0, 0, 0, 1, mk(9,8,0,0,0,0), 0, "R7 lower write while running");
        step(1, W_LOAD, 0, 0, 0, 0, mk(9,8,0,1,0,0), 0, "R11 write in error");
        step(1, W_FW, 0, 0, 0, 0, mk(9,8,0,1,0,0), 0, "R11 fw clear in error resets flag");
        step(1, W_CLR, 0, 0, 0, 0, mk(0,9,0,0,0,0), 0, "R9 clear from error");
        step(1, W_MOVE, 0, 0, 0, 0, mk(9,0,0,1,0,1), 0, "R4 move in RESET");
        step(1, W_CLR, 0, 0, 0, 0, mk(0,9,0,0,0,0), 0, "R9 clear drops move");
        step(1, W_LOAD | W_MOVE, 0, 0, 0, 0, mk(9,0,0,1,0,1), 0, "R8 load and move");
        step(1, W_CLR, 0, 0, 0, 0, mk(0,9,0,0,0,0), 0, "R9 clear again");
        step(1, W_LOAD, 0, 0, 0, 0, mk(2,1,0,0,0,0), 0, "R2 load");
        step(1, W_MOVE, 0, 0, 0, 0, mk(6,2,0,0,0,1), 1, "R4 move");
        step(1, W_LOAD, 0, 0, 0, 0, mk(2,1,0,0,0,0), 0, "R2 load from SYNC_WAIT");
        step(1, W_MOVE, 0, 0, 0, 0, mk(6,2,0,0,0,1), 1, "R4 move again");
        step(1, W_MOVE, 1, 0, 0, 0, mk(6,2,0,0,0,1), 1, "R12 write beats sync pulse");
        step(0, 0, 1, 0, 0, 0, mk(7,6,0,0,1,1), 1, "R5 sync pulse");
        step(1, W_LOAD, 0, 0, 0, 0, mk(9,7,0,1,0,0), 0, "R3 load in GET_TOD");
        step(1, W_CLR, 0, 0, 0, 0, mk(0,9,0,0,0,0), 0, "R9 clear");
        step(1, W_LOAD, 0, 0, 0, 0, mk(2,1,0,0,0,0), 0, "R2 load");
        step(1, W_MOVE, 0, 0, 0, 0, mk(6,2,0,0,0,1), 1, "R4 move");
        step(0, 0, 0, 0, 1, 0, mk(9,6,0,0,0,1), 0, "R7 upper write in SYNC_WAIT");
        step(1, W_CLR, 0, 0, 0, 0, mk(0,9,0,0,0,0), 0, "R9 clear");
        step(0, 0, 0, 1, 0, 0, mk(0,9,0,0,0,0), 0, "R6 strobe ignored when not ready");
        step(1, W_LOAD, 0, 0, 0, 0, mk(2,1,0,0,0,0), 0, "R2 load");
        step(1, W_MOVE, 0, 0, 0, 0, mk(6,2,0,0,0,1), 1, "R4 move");
        step(0, 0, 1, 0, 0, 0, mk(7,6,0,0,1,1), 1, "R5 sync pulse");
        step(0, 0, 0, 0, 0, 0, mk(7,6,0,0,1,1), 1, "R6 waits for strobe");
        step(0, 0, 0, 1, 0, 0, mk(8,7,1,0,1,0), 0, "R6 strobe in GET_TOD");
        step(1, W_LOAD, 0, 0, 0, 0, mk(2,1,0,0,0,0), 0, "R2 load from running");
        step(0, 0, 0, 0, 0, 0, mk(2,1,0,0,0,0), 0, "R10 history stable");
        @(negedge clk);
        wr_en = 0; wr_data = '0; sync_pulse = 0;
        tod_delivered = 0; tb_upper_wr = 0; tb_lower_wr = 0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule